// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block computes the next instruction address for a 32-bit RISC pipeline that has one architectural delay slot. Each time an instruction retires, the unit looks at the control-transfer kind that decode has already found, and at the compare flag, the branch offset or register target, and the saved exception state. From these it gives the address to execute next. It also gives a link-register write request and a status-register restore request. A taken transfer does not redirect at once. The unit arms an internal pending redirect, so the one instruction that follows still runs, and the redirect applies when that delay-slot instruction retires.

The pipeline drives `adv_i` high for each cycle in which the instruction at `pc_i` retires. While `adv_i` is low the unit holds its state, so a pending redirect survives any number of stall cycles. Return from exception is the one transfer without a delay slot: it takes its address from the saved exception PC and copies the saved status word back.

Top module: `nextpc_unit`

## Requirements
- R1: During and right after reset, `slot_pend_o` is 0, and no link write or status write is requested.
- R2: With no transfer (code 0), or with a conditional branch that is not taken, `fetch_pc_o` is `pc_i`+4 and no redirect is armed.
- R3: Transfer code 1 branches when `flag_i` is 1. Transfer code 2 branches when `flag_i` is 0.
- R4: A taken branch (codes 1, 2) or a relative jump (codes 3 jump, 4 jump-and-link) gives `fetch_pc_o` = `pc_i`+4 and arms a redirect, so `slot_pend_o` is 1 from the next clock. The redirect target is `pc_i` plus the sign-extended 26-bit `ofs_i` times 4, with the sum taken modulo 2^32.
- R5: Register jumps (code 5 jump-register, code 6 jump-and-link-register) arm a redirect to the full 32-bit `rtgt_i`.
- R6: Codes 4 and 6 raise `lnk_we_o` on their retirement, with `lnk_idx_o` = 9 and `lnk_val_o` = `pc_i`+8 modulo 2^32.
- R7: Code 7 (return from exception) gives `fetch_pc_o` = `epc_i` with no delay slot and raises `sr_we_o` with `sr_val_o` = `esr_i`. The next cycle `slot_pend_o` is 0.
- R8: While `slot_pend_o` is 1, `fetch_pc_o` equals the armed target. On the next retirement the redirect is consumed and `slot_pend_o` returns to 0.
- R9: A pending redirect survives any number of cycles with `adv_i` low. It is applied only when the delay-slot instruction retires.
- R10: The transfer code of the delay-slot instruction itself is ignored. It requests no link write and no status write, and it arms no new redirect.
- R11: With `adv_i` low, `lnk_we_o` and `sr_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | The instruction at `pc_i` retires this cycle |
| pc_i | input | 32 | Address of the retiring instruction |
| xfer_i | input | 3 | Transfer code: 0 none, 1 branch-if-set, 2 branch-if-clear, 3 jump, 4 jump-and-link, 5 jump-register, 6 jump-and-link-register, 7 return-from-exception |
| ofs_i | input | 26 | Signed word offset for relative transfers |
| rtgt_i | input | 32 | Register operand holding an absolute target |
| flag_i | input | 1 | Compare flag |
| epc_i | input | 32 | Saved exception PC |
| esr_i | input | 32 | Saved status word |
| fetch_pc_o | output | 32 | Address of the instruction to execute next |
| lnk_we_o | output | 1 | Link register write request |
| lnk_idx_o | output | 5 | Link register index (9) |
| lnk_val_o | output | 32 | Link value |
| sr_we_o | output | 1 | Status register restore request |
| sr_val_o | output | 32 | Status value to restore |
| slot_pend_o | output | 1 | A redirect is armed and waits for the delay slot to retire |

## Verification
The bench aims at the offset extremes: the most negative and the most positive 26-bit offsets. A design that zero-extends the offset, or forgets the times-four scaling, would land far from the target. It also covers the 32-bit wrap of both the link value and the slot address, and both polarities of each conditional branch. A branch with inverted sense would either redirect on a fall-through or fall through on a taken branch. Stall cycles between a transfer and its delay slot catch a unit that drops the redirect or applies it early. A transfer placed inside the delay slot catches a unit that lets it re-arm or write the link. A return from exception checks that no delay slot is inserted there.

// File: rtl/nxp_pkg.sv
package nxp_pkg;
   typedef enum logic [2:0] {
      XF_NONE  = 3'd0,
      XF_BSET  = 3'd1,
      XF_BCLR  = 3'd2,
      XF_JREL  = 3'd3,
      XF_JLREL = 3'd4,
      XF_JREG  = 3'd5,
      XF_JLREG = 3'd6,
      XF_ERET  = 3'd7
   } xfer_e;

   typedef struct packed {
      logic redirect;
      logic link;
      logic use_reg;
      logic eret;
   } xfer_dec_t;
endpackage

// File: rtl/nxp_cond.sv
module nxp_cond
   import nxp_pkg::*;
(
   input  logic [2:0] code_i,
   input  logic       flag_i,
   output xfer_dec_t  dec_o
);
   xfer_e kind;
   assign kind = xfer_e'(code_i);

   always_comb begin
      dec_o = '0;
      unique case (kind)
         XF_BSET:  dec_o.redirect = flag_i;
         XF_BCLR:  dec_o.redirect = ~flag_i;
         XF_JREL:  dec_o.redirect = 1'b1;
         XF_JLREL: begin dec_o.redirect = 1'b1; dec_o.link = 1'b1; end
         XF_JREG:  begin dec_o.redirect = 1'b1; dec_o.use_reg = 1'b1; end
         XF_JLREG: begin
            dec_o.redirect = 1'b1; dec_o.use_reg = 1'b1; dec_o.link = 1'b1;
         end
         XF_ERET:  dec_o.eret = 1'b1;
         default:  dec_o = '0;
      endcase
   end
endmodule

// File: rtl/nxp_target.sv
module nxp_target #(
   parameter int AW          = 32,
   parameter int OFS_W       = 26,
   parameter int INSN_BYTES  = 4,
   parameter bit ALIGN_REG   = 1'b0
) (
   input  logic [AW-1:0]    pc_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic [AW-1:0]    rtgt_i,
   input  logic             use_reg_i,
   output logic [AW-1:0]    tgt_o
);
   localparam int SH   = $clog2(INSN_BYTES);
   localparam int XTND = AW - OFS_W - SH;

   generate
      if (XTND < 1) begin : g_bad_width
         $error("nxp_target: AW too small for offset field");
      end
      if ((1 << SH) != INSN_BYTES) begin : g_bad_insn
         $error("nxp_target: INSN_BYTES must be a power of two");
      end
   endgenerate

   logic [AW-1:0] rel_disp;
   logic [AW-1:0] rel_tgt;
   logic [AW-1:0] reg_tgt;

   assign rel_disp = {{XTND{ofs_i[OFS_W-1]}}, ofs_i, {SH{1'b0}}};
   assign rel_tgt  = pc_i + rel_disp;

   generate
      if (ALIGN_REG) begin : g_align
         assign reg_tgt = {rtgt_i[AW-1:SH], {SH{1'b0}}};
      end else begin : g_raw
         assign reg_tgt = rtgt_i;
      end
   endgenerate

   assign tgt_o = use_reg_i ? reg_tgt : rel_tgt;
endmodule

// File: rtl/nxp_slot.sv
module nxp_slot #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic          arm_i,
   input  logic [AW-1:0] tgt_i,
   output logic          pend_o,
   output logic [AW-1:0] tgt_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o  <= 1'b0;
         tgt_q_o <= '0;
      end else if (adv_i) begin
         if (pend_o) begin
            pend_o <= 1'b0;
         end else if (arm_i) begin
            pend_o  <= 1'b1;
            tgt_q_o <= tgt_i;
         end
      end
   end

   // R9: a stall keeps the armed redirect and its target
   a_r9_stall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !adv_i) |=> (pend_o && $stable(tgt_q_o)));
   // R8: retiring the slot consumes the redirect
   a_r8_slot_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && adv_i) |=> !pend_o);
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
   import nxp_pkg::*;
#(
   parameter int AW         = 32,
   parameter int OFS_W      = 26,
   parameter int SR_W       = 32,
   parameter int RIDX_W     = 5,
   parameter int LINK_IDX   = 9,
   parameter int INSN_BYTES = 4,
   parameter bit ALIGN_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [2:0]        xfer_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [AW-1:0]     rtgt_i,
   input  logic              flag_i,
   input  logic [AW-1:0]     epc_i,
   input  logic [SR_W-1:0]   esr_i,
   output logic [AW-1:0]     fetch_pc_o,
   output logic              lnk_we_o,
   output logic [RIDX_W-1:0] lnk_idx_o,
   output logic [AW-1:0]     lnk_val_o,
   output logic              sr_we_o,
   output logic [SR_W-1:0]   sr_val_o,
   output logic              slot_pend_o
);
   localparam logic [AW-1:0]     STEP     = AW'(INSN_BYTES);
   localparam logic [AW-1:0]     LINK_OFS = AW'(2 * INSN_BYTES);
   localparam logic [RIDX_W-1:0] LINK_R   = RIDX_W'(LINK_IDX);

   generate
      if (LINK_IDX >= (1 << RIDX_W)) begin : g_bad_link
         $error("nextpc_unit: LINK_IDX does not fit RIDX_W");
      end
   endgenerate

   xfer_dec_t     dec;
   logic [AW-1:0] new_tgt;
   logic [AW-1:0] held_tgt;
   logic          live;

   nxp_cond u_cond (
      .code_i (xfer_i),
      .flag_i (flag_i),
      .dec_o  (dec)
   );

   nxp_target #(
      .AW(AW), .OFS_W(OFS_W), .INSN_BYTES(INSN_BYTES), .ALIGN_REG(ALIGN_REG)
   ) u_tgt (
      .pc_i      (pc_i),
      .ofs_i     (ofs_i),
      .rtgt_i    (rtgt_i),
      .use_reg_i (dec.use_reg),
      .tgt_o     (new_tgt)
   );

   nxp_slot #(.AW(AW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (adv_i),
      .arm_i   (dec.redirect),
      .tgt_i   (new_tgt),
      .pend_o  (slot_pend_o),
      .tgt_q_o (held_tgt)
   );

   // the instruction in the delay slot has its transfer suppressed
   assign live = adv_i & ~slot_pend_o;

   always_comb begin
      if (slot_pend_o)   fetch_pc_o = held_tgt;
      else if (dec.eret) fetch_pc_o = epc_i;
      else               fetch_pc_o = pc_i + STEP;
   end

   assign lnk_we_o  = live & dec.link;
   assign lnk_idx_o = LINK_R;
   assign lnk_val_o = pc_i + LINK_OFS;
   assign sr_we_o   = live & dec.eret;
   assign sr_val_o  = esr_i;

   // R4: a redirect decoded on a live retirement arms the slot
   a_r4_arms_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (live && dec.redirect) |=> slot_pend_o);
   // R7: an exception return never leaves a delay slot behind
   a_r7_no_slot_after_eret: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we_o |=> !slot_pend_o);
   // R11: no side effects without retirement
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |-> (!lnk_we_o && !sr_we_o));
   // R10: side effects never appear while the slot is pending
   a_r10_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      slot_pend_o |-> (!lnk_we_o && !sr_we_o));
   // R6: link and status writes are mutually exclusive
   a_r6_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({lnk_we_o, sr_we_o}) <= 1);
endmodule

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb_top;
   typedef struct packed {
      logic [2:0]  xf;
      logic        fl;
      logic [31:0] pc;
      logic [25:0] ofs;
      logic [31:0] rt;
      logic        taken;
      logic [31:0] dest;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 1'b0, 32'h0000_0100, 26'h0000005, 32'h0,         1'b0, 32'h0000_0104},
      '{3'd1, 1'b0, 32'h0000_0200, 26'h0000005, 32'h0,         1'b0, 32'h0000_0204},
      '{3'd1, 1'b1, 32'h0000_0200, 26'h0000005, 32'h0,         1'b1, 32'h0000_0214},
      '{3'd2, 1'b0, 32'h0000_1000, 26'h3FFFFFE, 32'h0,         1'b1, 32'h0000_0FF8},
      '{3'd2, 1'b1, 32'h0000_1000, 26'h3FFFFFE, 32'h0,         1'b0, 32'h0000_1004},
      '{3'd3, 1'b0, 32'h0000_4000, 26'h2000000, 32'h0,         1'b1, 32'hF800_4000},
      '{3'd4, 1'b1, 32'h0000_0080, 26'h1FFFFFF, 32'h0,         1'b1, 32'h0800_007C},
      '{3'd5, 1'b0, 32'h0000_0300, 26'h0000000, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF},
      '{3'd6, 1'b1, 32'hFFFF_FFFC, 26'h0000001, 32'h0000_0010, 1'b1, 32'h0000_0010},
      '{3'd5, 1'b1, 32'h0000_0500, 26'h0000001, 32'h1234_5670, 1'b1, 32'h1234_5670}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv = 1'b0;
   logic [31:0] pc = '0;
   logic [2:0]  xf = '0;
   logic [25:0] ofs = '0;
   logic [31:0] rt = '0;
   logic        fl = 1'b0;
   logic [31:0] epc = '0;
   logic [31:0] esr = '0;
   logic [31:0] fetch_pc;
   logic        lnk_we;
   logic [4:0]  lnk_idx;
   logic [31:0] lnk_val;
   logic        sr_we;
   logic [31:0] sr_val;
   logic        pend;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nextpc_unit dut_i (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .pc_i(pc), .xfer_i(xf),
      .ofs_i(ofs), .rtgt_i(rt), .flag_i(fl), .epc_i(epc), .esr_i(esr),
      .fetch_pc_o(fetch_pc), .lnk_we_o(lnk_we), .lnk_idx_o(lnk_idx),
      .lnk_val_o(lnk_val), .sr_we_o(sr_we), .sr_val_o(sr_val),
      .slot_pend_o(pend)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // drive at the falling edge, sample 5 ns later, before the rising edge
   task automatic drive(input logic a, input logic [2:0] x, input logic f,
                        input logic [31:0] p, input logic [25:0] o, input logic [31:0] r);
      @(negedge clk);
      adv = a; xf = x; fl = f; pc = p; ofs = o; rt = r;
      #5;
   endtask

   function automatic bit links(input logic [2:0] x);
      return (x == 3'd4) || (x == 3'd6);
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      #5;
      chk({31'b0, pend}, 32'd0, "R1 pend in reset");
      chk({30'b0, lnk_we, sr_we}, 32'd0, "R1 writes in reset");
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      chk({31'b0, pend}, 32'd0, "R1 pend after reset");

      // table walk: R2 R3 R4 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VEC[i].xf, VEC[i].fl, VEC[i].pc, VEC[i].ofs, VEC[i].rt);
         chk({31'b0, lnk_we}, {31'b0, links(VEC[i].xf)}, $sformatf("R6 link we vec %0d", i));
         if (links(VEC[i].xf)) begin
            chk(lnk_val, VEC[i].pc + 32'd8, $sformatf("R6 link value vec %0d", i));
            chk({27'b0, lnk_idx}, 32'd9, $sformatf("R6 link index vec %0d", i));
         end
         if (VEC[i].taken) begin
            chk(fetch_pc, VEC[i].pc + 32'd4, $sformatf("R4 slot address vec %0d", i));
            drive(1'b1, 3'd0, 1'b0, VEC[i].pc + 32'd4, 26'd0, 32'd0);
            chk({31'b0, pend}, 32'd1, $sformatf("R4 armed vec %0d", i));
            chk(fetch_pc, VEC[i].dest, $sformatf("R4/R5 target vec %0d", i));
            drive(1'b0, 3'd0, 1'b0, VEC[i].dest, 26'd0, 32'd0);
            chk({31'b0, pend}, 32'd0, $sformatf("R8 consumed vec %0d", i));
         end else begin
            chk(fetch_pc, VEC[i].dest, $sformatf("R2/R3 fall-through vec %0d", i));
            drive(1'b0, 3'd0, 1'b0, VEC[i].pc, 26'd0, 32'd0);
            chk({31'b0, pend}, 32'd0, $sformatf("R2 nothing armed vec %0d", i));
         end
      end

      // R7: exception return, no slot
      epc = 32'h0000_2F00; esr = 32'h0000_8001;
      drive(1'b1, 3'd7, 1'b0, 32'h0000_0700, 26'd3, 32'd0);
      chk(fetch_pc, 32'h0000_2F00, "R7 fetch from epc");
      chk({31'b0, sr_we}, 32'd1, "R7 sr write");
      chk(sr_val, 32'h0000_8001, "R7 sr value");
      drive(1'b1, 3'd0, 1'b0, 32'h0000_2F00, 26'd0, 32'd0);
      chk({31'b0, pend}, 32'd0, "R7 no slot pending");
      chk(fetch_pc, 32'h0000_2F04, "R7 sequential after return");

      // R9: stall between transfer and slot
      drive(1'b1, 3'd3, 1'b0, 32'h0000_0900, 26'h0000010, 32'd0);
      for (int k = 0; k < 4; k++) begin
         drive(1'b0, 3'd4, 1'b0, 32'h0000_0904, 26'h0000077, 32'd0);
         chk({31'b0, pend}, 32'd1, $sformatf("R9 pending held stall %0d", k));
         chk({31'b0, lnk_we}, 32'd0, $sformatf("R11 no link while stalled %0d", k));
      end
      drive(1'b1, 3'd0, 1'b0, 32'h0000_0904, 26'd0, 32'd0);
      chk(fetch_pc, 32'h0000_0940, "R9 target after stall");

      // R10: transfer in the delay slot is ignored
      drive(1'b1, 3'd3, 1'b0, 32'h0000_0A00, 26'h0000004, 32'd0);
      drive(1'b1, 3'd4, 1'b0, 32'h0000_0A04, 26'h0000100, 32'd0);
      chk(fetch_pc, 32'h0000_0A10, "R10 slot transfer keeps first target");
      chk({31'b0, lnk_we}, 32'd0, "R10 slot link suppressed");
      drive(1'b1, 3'd7, 1'b0, 32'h0000_0A10, 26'd0, 32'd0);
      chk({31'b0, pend}, 32'd0, "R10 slot did not re-arm");
      chk({31'b0, sr_we}, 32'd1, "R7 return after slot sequence");

      // R11: no retirement, no side effects, nothing armed
      drive(1'b0, 3'd6, 1'b0, 32'h0000_0B00, 26'd0, 32'h40);
      chk({31'b0, lnk_we}, 32'd0, "R11 link idle");
      drive(1'b0, 3'd7, 1'b0, 32'h0000_0B00, 26'd0, 32'h40);
      chk({31'b0, sr_we}, 32'd0, "R11 sr idle");
      chk({31'b0, pend}, 32'd0, "R11 nothing armed while idle");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule